// File: doc/BRIEF.md
# Dual ATA Device Bus Wrapper

This block places two ATA device models, device 0 and device 1, behind one shared 8-bit task-file register bus. Two static configuration inputs say which devices are fitted, and a per-device flag marks a device as a packet-command device. The wrapper hands out device identities, orders the hardware reset of the two devices and chains the diagnostic handshake lines from device 1 to device 0. It broadcasts every register write to each fitted device and returns each read from the device that currently answers.

When only device 1 is fitted, it takes identity 0 and behaves as the logical device 0 on the bus. When no device is fitted, reads return zero, writes are dropped and a sticky error flag is raised. The aggregated interrupt line follows the answering device, and only while that device is the one the device/head DEV bit selects.

Both the asynchronous power-on reset `rst_ni` and the bus hardware reset `hw_reset_i` put the devices into their reset state. A device leaves reset on the first clock edge at which its reset request is low. All reads are combinational from `addr_i`. `rd_en_i` marks a read access for its side effects only.

Top module: `ata_pair_wrap`

## Requirements
- R1: While a device is in reset its status register (address 6) reads 0x80 (busy, bit 7). After release it reads 0x40 (ready, bit 6) for a non-packet device and 0x00 for a packet device. On entering reset the registers take sector count 1, sector number 1, and cylinder low, cylinder high and device/head 0.
- R2: With both devices fitted, device 1 leaves hardware reset on the first clock edge after `hw_reset_i` falls and device 0 one edge later. A lone device leaves reset on the first edge.
- R3: At release, device 0 records diagnostic code 0x01 in its error register (address 0, read) when device 1 is absent, or when device 1 is present and has signalled a passed diagnosis. The code is 0x81 when a peer announces itself without passing.
- R4: Device 1 takes identity 1 only when device 0 is fitted. Alone, it answers status reads when DEV (device/head bit 4) is 0 and reads status 0 when DEV is 1.
- R5: With both devices fitted, reads come from device 1 when DEV is 1 and from device 0 otherwise. With one device fitted, that device always answers.
- R6: Every register write reaches each fitted device. The writable registers are sector count (1), sector number (2), cylinder low (3), cylinder high (4) and device/head (5).
- R7: With no device fitted, `rdata_o` is 0, writes are dropped, and `no_dev_err_o` rises after the first read or write access and holds until `rst_ni`.
- R8: A write to address 6 (command) raises the interrupt of each device whose identity matches DEV. `intrq_o` shows the answering device's interrupt only while DEV matches its identity. A read access to address 6 clears it, and a read of address 7 (alternate status) leaves it set.
- R9: Status and alternate status (addresses 6 and 7) read 0 from a device whose identity differs from DEV. Other registers still read their contents.
- R10: Writes that arrive while a device is in reset, including its release cycle, are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| dev0_present_i | input | 1 | Device 0 fitted (static) |
| dev1_present_i | input | 1 | Device 1 fitted (static) |
| dev0_packet_i | input | 1 | Device 0 is a packet-command device |
| dev1_packet_i | input | 1 | Device 1 is a packet-command device |
| hw_reset_i | input | 1 | Bus hardware reset, active high |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read access strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data from the answering device |
| intrq_o | output | 1 | Interrupt of the answering, selected device |
| no_dev_err_o | output | 1 | Sticky flag: access attempted with no device fitted |

## Verification
The bench builds the wrapper with its default 3-bit address and 8-bit register width. It steps through all four presence combinations, with packet flags picked at random per combination, by re-applying `rst_ni` between them. This brings within reach the one-cycle skew between the two devices' reset release, the promotion of a lone device 1, the routing switch on the DEV bit and the no-device error path. Random write and read sequences, including writes to the dropped addresses 0 and 7, are compared against a register shadow kept in the bench.

// File: rtl/ata_pair_pkg.sv
package ata_pair_pkg;
  localparam int unsigned REG_AW = 3;
  localparam int unsigned REG_DW = 8;

  localparam logic [REG_AW-1:0] A_ERR  = 3'd0;
  localparam logic [REG_AW-1:0] A_SCNT = 3'd1;
  localparam logic [REG_AW-1:0] A_SNUM = 3'd2;
  localparam logic [REG_AW-1:0] A_CYLL = 3'd3;
  localparam logic [REG_AW-1:0] A_CYLH = 3'd4;
  localparam logic [REG_AW-1:0] A_DH   = 3'd5;
  localparam logic [REG_AW-1:0] A_STAT = 3'd6;
  localparam logic [REG_AW-1:0] A_ALT  = 3'd7;

  localparam int unsigned ST_BSY  = 7;
  localparam int unsigned ST_DRDY = 6;
  localparam int unsigned DH_DEV  = 4;

  localparam logic [REG_DW-1:0] DIAG_PASS = 8'h01;
  localparam logic [REG_DW-1:0] DIAG_PEER = 8'h81;
endpackage

// File: rtl/ata_dev_model.sv
module ata_dev_model
  import ata_pair_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dev_id_i,
  input  logic              packet_i,
  input  logic              hrst_i,
  input  logic              dasp_drive_i,
  input  logic              pdiag_i,
  input  logic              dasp_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  output logic [REG_DW-1:0] rdata_o,
  output logic              intrq_o,
  output logic              pdiag_o,
  output logic              dasp_o,
  output logic              busy_o,
  output logic              dev_bit_o
);
  logic              in_rst;
  logic [REG_DW-1:0] status_q, err_q, scnt_q, snum_q, cyll_q, cylh_q, dh_q;
  logic              intrq_q, pdiag_q, dasp_q;
  logic              selected;

  assign selected = (dh_q[DH_DEV] == dev_id_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_rst   <= 1'b1;
      status_q <= 8'h80;
      err_q    <= '0;
      scnt_q   <= 8'd1;
      snum_q   <= 8'd1;
      cyll_q   <= '0;
      cylh_q   <= '0;
      dh_q     <= '0;
      intrq_q  <= 1'b0;
      pdiag_q  <= 1'b0;
      dasp_q   <= 1'b0;
    end else if (hrst_i) begin
      in_rst   <= 1'b1;
      status_q <= 8'h80;
      scnt_q   <= 8'd1;
      snum_q   <= 8'd1;
      cyll_q   <= '0;
      cylh_q   <= '0;
      dh_q     <= '0;
      intrq_q  <= 1'b0;
      pdiag_q  <= 1'b0;
      dasp_q   <= dasp_drive_i;
    end else if (in_rst) begin
      // release: run diagnostics against the peer's handshake lines
      in_rst   <= 1'b0;
      status_q <= packet_i ? 8'h00 : (8'h01 << ST_DRDY);
      err_q    <= (dasp_i && !pdiag_i) ? DIAG_PEER : DIAG_PASS;
      pdiag_q  <= 1'b1;
      dasp_q   <= dasp_drive_i;
    end else begin
      if (rd_en_i && addr_i == A_STAT && selected) intrq_q <= 1'b0;
      if (wr_en_i) begin
        unique case (addr_i)
          A_SCNT:  scnt_q <= wdata_i;
          A_SNUM:  snum_q <= wdata_i;
          A_CYLL:  cyll_q <= wdata_i;
          A_CYLH:  cylh_q <= wdata_i;
          A_DH:    dh_q   <= wdata_i;
          A_STAT:  if (selected) intrq_q <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      A_ERR:         rdata_o = err_q;
      A_SCNT:        rdata_o = scnt_q;
      A_SNUM:        rdata_o = snum_q;
      A_CYLL:        rdata_o = cyll_q;
      A_CYLH:        rdata_o = cylh_q;
      A_DH:          rdata_o = dh_q;
      A_STAT, A_ALT: rdata_o = selected ? status_q : '0;
      default:       rdata_o = '0;
    endcase
  end

  assign intrq_o   = intrq_q;
  assign pdiag_o   = pdiag_q;
  assign dasp_o    = dasp_q;
  assign busy_o    = in_rst;
  assign dev_bit_o = dh_q[DH_DEV];

  assert_busy_in_reset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hrst_i |=> (busy_o && status_q[ST_BSY]));

  assert_intrq_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i && !hrst_i && !in_rst && addr_i == A_STAT && selected) |=> !intrq_o);

  assert_drop_busy_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_rst && !hrst_i) |=> ($stable(scnt_q) && $stable(cyll_q) && $stable(dh_q)));
endmodule

// File: rtl/ata_rst_seq.sv
module ata_rst_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic both_i,
  input  logic hrst_i,
  output logic rst0_o,
  output logic rst1_o
);
  logic hrst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hrst_q <= 1'b1;
    else         hrst_q <= hrst_i;
  end

  // device 1 released first; device 0 held one extra edge to see its handshake
  assign rst1_o = hrst_i;
  assign rst0_o = hrst_i | (both_i & hrst_q);
endmodule

// File: rtl/ata_rd_route.sv
module ata_rd_route
  import ata_pair_pkg::*;
(
  input  logic              p0_i,
  input  logic              p1_i,
  input  logic              id1_i,
  input  logic              rd_en_i,
  input  logic [1:0]        dev_bit_i,
  input  logic [1:0]        intrq_i,
  input  logic [REG_DW-1:0] rdata0_i,
  input  logic [REG_DW-1:0] rdata1_i,
  output logic [REG_DW-1:0] rdata_o,
  output logic              intrq_o,
  output logic              rd0_o,
  output logic              rd1_o
);
  logic none, pick1, sel0, sel1;

  assign none  = !p0_i && !p1_i;
  assign pick1 = p1_i && (!p0_i || dev_bit_i[1]);
  assign sel0  = !dev_bit_i[0];
  assign sel1  = (dev_bit_i[1] == id1_i);

  assign rdata_o = none ? '0 : (pick1 ? rdata1_i : rdata0_i);
  assign intrq_o = !none && (pick1 ? (intrq_i[1] && sel1) : (intrq_i[0] && sel0));
  assign rd1_o   = rd_en_i && pick1;
  assign rd0_o   = rd_en_i && p0_i && !pick1;

  always_comb begin
    assert_one_reader_R5: assert (!(rd0_o && rd1_o));
  end
endmodule

// File: rtl/ata_pair_wrap.sv
module ata_pair_wrap
  import ata_pair_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dev0_present_i,
  input  logic              dev1_present_i,
  input  logic              dev0_packet_i,
  input  logic              dev1_packet_i,
  input  logic              hw_reset_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  output logic [REG_DW-1:0] rdata_o,
  output logic              intrq_o,
  output logic              no_dev_err_o
);
  logic              both, none, id1, rst0, rst1, rd0, rd1;
  logic [1:0]        dev_bit, intrq, pdiag, dasp, busy;
  logic [REG_DW-1:0] rdata0, rdata1;
  logic              no_dev_q;

  assign both = dev0_present_i && dev1_present_i;
  assign none = !dev0_present_i && !dev1_present_i;
  assign id1  = dev0_present_i;

  ata_rst_seq u_rst_seq (
    .clk_i, .rst_ni, .both_i(both), .hrst_i(hw_reset_i), .rst0_o(rst0), .rst1_o(rst1)
  );

  ata_dev_model u_dev0 (
    .clk_i, .rst_ni, .dev_id_i(1'b0), .packet_i(dev0_packet_i), .hrst_i(rst0),
    .dasp_drive_i(1'b0), .pdiag_i(both && pdiag[1]), .dasp_i(both && dasp[1]),
    .wr_en_i(wr_en_i && dev0_present_i), .rd_en_i(rd0), .addr_i, .wdata_i,
    .rdata_o(rdata0), .intrq_o(intrq[0]), .pdiag_o(pdiag[0]), .dasp_o(dasp[0]),
    .busy_o(busy[0]), .dev_bit_o(dev_bit[0])
  );

  ata_dev_model u_dev1 (
    .clk_i, .rst_ni, .dev_id_i(id1), .packet_i(dev1_packet_i), .hrst_i(rst1),
    .dasp_drive_i(both), .pdiag_i(1'b0), .dasp_i(1'b0),
    .wr_en_i(wr_en_i && dev1_present_i), .rd_en_i(rd1), .addr_i, .wdata_i,
    .rdata_o(rdata1), .intrq_o(intrq[1]), .pdiag_o(pdiag[1]), .dasp_o(dasp[1]),
    .busy_o(busy[1]), .dev_bit_o(dev_bit[1])
  );

  ata_rd_route u_route (
    .p0_i(dev0_present_i), .p1_i(dev1_present_i), .id1_i(id1), .rd_en_i,
    .dev_bit_i(dev_bit), .intrq_i(intrq), .rdata0_i(rdata0), .rdata1_i(rdata1),
    .rdata_o, .intrq_o, .rd0_o(rd0), .rd1_o(rd1)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          no_dev_q <= 1'b0;
    else if (none && (wr_en_i || rd_en_i)) no_dev_q <= 1'b1;
  end
  assign no_dev_err_o = no_dev_q;

  assert_dev1_leads_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (both && $fell(busy[0])) |-> !busy[1]);

  assert_nodev_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (none && (wr_en_i || rd_en_i)) |=> no_dev_err_o);

  assert_nodev_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    none |-> (rdata_o == '0 && !intrq_o));

  assert_peer_diag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (both && $fell(busy[0])) |-> (pdiag[1] && dasp[1]));
endmodule

// File: tb/tb_ata_pair_wrap.sv
module tb_ata_pair_wrap;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       p0 = 1'b1, p1 = 1'b1, k0 = 1'b0, k1 = 1'b0;
  logic       hw_reset_i = 1'b0, wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       intrq_o, no_dev_err_o;

  int unsigned n_chk = 0, n_fail = 0;
  logic [7:0] sh [1:5];

  always #2 clk_i = ~clk_i;

  ata_pair_wrap dut (
    .clk_i, .rst_ni, .dev0_present_i(p0), .dev1_present_i(p1),
    .dev0_packet_i(k0), .dev1_packet_i(k1), .hw_reset_i, .wr_en_i, .rd_en_i,
    .addr_i, .wdata_i, .rdata_o, .intrq_o, .no_dev_err_o
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    addr_i = a; #1 d = rdata_o;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i); wr_en_i = 1'b0;
    if (a >= 3'd1 && a <= 3'd5) sh[a] = d;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk_i); addr_i = a; rd_en_i = 1'b1; #1 d = rdata_o;
    @(posedge clk_i); @(negedge clk_i); rd_en_i = 1'b0;
  endtask

  task automatic setup(input logic a0, input logic a1, input logic b0, input logic b1);
    @(negedge clk_i); rst_ni = 1'b0; p0 = a0; p1 = a1; k0 = b0; k1 = b1;
    hw_reset_i = 1'b0; wr_en_i = 1'b0; rd_en_i = 1'b0;
    sh[1] = 8'd1; sh[2] = 8'd1; sh[3] = 8'd0; sh[4] = 8'd0; sh[5] = 8'd0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
  endtask

  // expected read value from the bench's own view of the requirements
  function automatic logic [7:0] exp_read(input logic [2:0] a);
    logic pick1, id, pk;
    if (!p0 && !p1) return 8'h00;
    pick1 = p1 && (!p0 || sh[5][4]);
    id    = pick1 ? p0 : 1'b0;
    pk    = pick1 ? k1 : k0;
    case (a)
      3'd0:       return 8'h01;
      3'd6, 3'd7: return (sh[5][4] == id) ? (pk ? 8'h00 : 8'h40) : 8'h00;
      default:    return sh[a];
    endcase
  endfunction

  initial begin
    #600000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5eed_1234));

    // reset state
    p0 = 1'b1; p1 = 1'b1; k0 = 1'b0; k1 = 1'b1;
    repeat (2) @(negedge clk_i);
    peek(3'd6, d); check("R1 status in power-on reset", d, 8'h80);
    check("R1 intrq in reset", {7'd0, intrq_o}, 8'h00);
    check("R7 flag clear at reset", {7'd0, no_dev_err_o}, 8'h00);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    // both fitted: ordered release, write dropped during reset
    hw_reset_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    peek(3'd6, d); check("R1 busy during hw reset", d, 8'h80);
    addr_i = 3'd3; wdata_i = 8'h5a; wr_en_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    wr_en_i = 1'b0; hw_reset_i = 1'b0;
    @(posedge clk_i); @(negedge clk_i);
    peek(3'd6, d); check("R2 dev0 still busy one edge after release", d, 8'h80);
    @(posedge clk_i); @(negedge clk_i);
    peek(3'd6, d); check("R2 dev0 ready second edge", d, 8'h40);
    peek(3'd0, d); check("R3 dev0 diag with passing peer", d, 8'h01);
    peek(3'd3, d); check("R10 write during reset dropped", d, 8'h00);

    // broadcast and routing
    sh[1] = 8'd1; sh[2] = 8'd1; sh[3] = 8'd0; sh[4] = 8'd0; sh[5] = 8'd0;
    wr(3'd3, 8'h3c);
    wr(3'd5, 8'h10);
    peek(3'd3, d); check("R6 dev1 holds write made with DEV=0", d, 8'h3c);
    peek(3'd6, d); check("R5 DEV=1 routes to packet dev1", d, 8'h00);
    peek(3'd0, d); check("R3 dev1 diag alone in chain", d, 8'h01);
    wr(3'd4, 8'h77);
    wr(3'd5, 8'h00);
    peek(3'd4, d); check("R6 dev0 holds write made with DEV=1", d, 8'h77);
    peek(3'd6, d); check("R5 DEV=0 routes to dev0", d, 8'h40);

    // interrupt follows selected, answering device
    wr(3'd6, 8'hec);
    check("R8 command raises intrq", {7'd0, intrq_o}, 8'h01);
    wr(3'd5, 8'h10);
    check("R8 dev1 not interrupted", {7'd0, intrq_o}, 8'h00);
    wr(3'd5, 8'h00);
    check("R8 dev0 intrq visible again", {7'd0, intrq_o}, 8'h01);
    rd(3'd7, d);
    check("R8 alt status keeps intrq", {7'd0, intrq_o}, 8'h01);
    rd(3'd6, d); check("R8 status read value", d, 8'h40);
    check("R8 status read clears intrq", {7'd0, intrq_o}, 8'h00);

    // single device 0
    setup(1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk_i); hw_reset_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i); hw_reset_i = 1'b0;
    @(posedge clk_i); @(negedge clk_i);
    peek(3'd6, d); check("R2 lone dev0 ready first edge", d, 8'h40);
    peek(3'd0, d); check("R3 lone dev0 diag", d, 8'h01);
    wr(3'd6, 8'hec);
    check("R8 lone dev0 intrq", {7'd0, intrq_o}, 8'h01);
    wr(3'd5, 8'h10);
    check("R8 intrq hidden when unselected", {7'd0, intrq_o}, 8'h00);
    peek(3'd6, d); check("R9 unselected status zero", d, 8'h00);
    peek(3'd7, d); check("R9 unselected alt status zero", d, 8'h00);
    peek(3'd5, d); check("R9 device/head still readable", d, 8'h10);

    // single device 1 promoted
    setup(1'b0, 1'b1, 1'b0, 1'b0);
    peek(3'd6, d); check("R4 lone dev1 answers DEV=0", d, 8'h40);
    wr(3'd6, 8'hec);
    check("R4 lone dev1 takes command as device 0", {7'd0, intrq_o}, 8'h01);
    wr(3'd5, 8'h10);
    peek(3'd6, d); check("R4 lone dev1 silent on DEV=1", d, 8'h00);
    @(negedge clk_i); hw_reset_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i); hw_reset_i = 1'b0;
    @(posedge clk_i); @(negedge clk_i);
    peek(3'd6, d); check("R2 lone dev1 ready first edge", d, 8'h40);

    // nothing fitted
    setup(1'b0, 1'b0, 1'b0, 1'b0);
    peek(3'd6, d); check("R7 no device read", d, 8'h00);
    check("R7 flag before access", {7'd0, no_dev_err_o}, 8'h00);
    wr(3'd3, 8'h99);
    check("R7 flag after write", {7'd0, no_dev_err_o}, 8'h01);
    peek(3'd3, d); check("R7 write dropped", d, 8'h00);

    // random traffic per configuration
    for (int cfg = 0; cfg < 3; cfg++) begin
      setup(cfg != 2, cfg != 1, 1'($urandom), 1'($urandom));
      for (int i = 0; i < 300; i++) begin
        logic [2:0] a;
        a = 3'($urandom);
        if ($urandom % 2 == 0) begin
          if (a == 3'd6) a = 3'd7;
          wr(a, 8'($urandom));
        end else begin
          rd(a, d);
          check("R5 R6 R9 random read", d, exp_read(a));
          check("R8 no spurious intrq", {7'd0, intrq_o}, 8'h00);
        end
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule